// File: doc/BRIEF.md
# Two-Bank Split Word Memory

This block looks like one flat word-addressed memory to the logic that uses it, but stores its contents in two equal banks, each half the total depth. The least significant address bit picks the bank. The remaining upper address bits go to both banks as the address inside the bank. On any cycle only the chosen bank receives a chip enable, and a write enable when one is needed. The other bank does nothing, so each access switches about half the array.

Read data is registered and comes out one clock after the address. A registered copy of the bank choice drives each bank's active-low output enable during that following cycle, and the enabled bank alone places data on the combining logic. The full-size build sets `ADDR_W` to 15, which gives 32K words of 32 bits from two 16K x 32 banks. The default parameter value is smaller, so the behavioural arrays stay small when the design is elaborated on its own. A write also loads the written word into the bank's read register (write-through), so the following cycle shows it. Reset is synchronous and active-low.

Top module: `split_bank_mem`

## Requirements
- R1: While `rst_n` is low no bank is enabled and no write takes effect. In the cycle after a reset edge, `rdata` reads 0.
- R2: Bit 0 of `addr` selects the bank: 0 selects the even bank and 1 the odd bank. Exactly one bank is enabled on every cycle out of reset, so two addresses that differ only in bit 0 hold independent words.
- R3: Bits `ADDR_W-1` down to 1 of `addr` form the address inside the bank, so even (or odd) addresses with different upper bits hold independent words, up to the top address `2**ADDR_W-1`.
- R4: A read presented before clock edge k shows its word on `rdata` after edge k and not before. The bank whose output enable is active during that cycle is the one enabled at edge k.
- R5: With `wr_en` high at an edge, `wdata` is stored at `addr`, and `rdata` shows that same word in the following cycle.
- R6: A write to one bank never changes any word held by the other bank.
- R7: Back-to-back reads that alternate between even and odd addresses return the correct word on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address; bit 0 chooses the bank |
| wr_en | input | 1 | High for a write, low for a read |
| wdata | input | DATA_W | Word to store on a write |
| rdata | output | DATA_W | Word read, valid one cycle after its address |

## Verification
On every cycle the assertions check four things. Exactly one bank is enabled. A write strobe never reaches a bank without its chip enable. The output enable that is active in a cycle belongs to the bank enabled one edge before. A bank that was not enabled keeps its read register unchanged, and a write shows up on `rdata` one cycle later. Only the bench's scenarios can show that words actually land at the right place. Those scenarios cover independence between neighbouring even and odd addresses, independence across upper address bits at the top of the range, correct data through alternating reads, and writes blocked during reset.

// File: rtl/split_bank_pkg.sv
// Shared helpers for the two-bank split memory.
// Assumes the bank index is taken from the low address bits.
package split_bank_pkg;

    // Number of banks for a given bank-select width.
    function automatic int bank_count(input int sel_w);
        return 1 << sel_w;
    endfunction

endpackage

// File: rtl/bank_decoder.sv
// Bank decoder: turns the user address and strobe into per-bank chip and
// write enables and the bank-internal address.
// Assumes the low SEL_W address bits select the bank; nothing is enabled in reset.
module bank_decoder #(
    parameter int ADDR_W = 11,
    parameter int SEL_W  = 1,
    localparam int NBANK = split_bank_pkg::bank_count(SEL_W),
    localparam int BA_W  = ADDR_W - SEL_W
) (
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic [NBANK-1:0]  bank_ce,
    output logic [NBANK-1:0]  bank_we,
    output logic [BA_W-1:0]   bank_addr
);

    // Upper bits are shared by every bank.
    assign bank_addr = addr[ADDR_W-1:SEL_W];

    for (genvar b = 0; b < NBANK; b++) begin : g_dec
        // Enable one bank when its index matches the low address bits.
        always_comb begin
            bank_ce[b] = rst_n && (addr[SEL_W-1:0] == SEL_W'(b));
            bank_we[b] = bank_ce[b] && wr_en;
        end
    end

endmodule

// File: rtl/bank_array.sv
// Behavioural single-port bank with a registered read port and write-through.
// Assumes ce gates all activity; oe_n low lets the read register reach the output.
module bank_array #(
    parameter int BA_W   = 10,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << BA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic              oe_n,
    input  logic [BA_W-1:0]   addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Store the word on an enabled write.
    always_ff @(posedge clk) begin
        if (ce && we) mem[addr] <= wdata;
    end

    // Load the read register on any enabled access; hold it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)  rd_q <= '0;
        else if (ce) rd_q <= we ? wdata : mem[addr];
    end

    // Drive data only while the output enable is active.
    assign rdata = oe_n ? '0 : rd_q;

    // An idle bank must not change its read register.
    assert_idle_bank_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(rd_q));

endmodule

// File: rtl/read_select.sv
// Registered read select: remembers which bank was enabled, drives that bank's
// active-low output enable in the next cycle and combines the bank outputs.
// Assumes at most one bank is enabled per cycle.
module read_select #(
    parameter int DATA_W = 32,
    parameter int NBANK  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NBANK-1:0]              bank_ce,
    input  logic [NBANK-1:0][DATA_W-1:0]  bank_rdata,
    output logic [NBANK-1:0]              bank_oe_n,
    output logic [DATA_W-1:0]             rdata
);

    logic [NBANK-1:0] sel_q;

    // Capture the bank choice of this access for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= bank_ce;
    end

    assign bank_oe_n = ~sel_q;

    // Combine the masked bank outputs into the user read data.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (sel_q[b]) rdata = rdata | bank_rdata[b];
        end
    end

endmodule

// File: rtl/split_bank_mem.sv
// Two-bank split memory top: one flat word address space built from banks
// chosen by the low address bit, one bank active per access.
// Assumes every cycle out of reset is an access (read or write).
module split_bank_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 1,
    localparam int NBANK = split_bank_pkg::bank_count(SEL_W),
    localparam int BA_W  = ADDR_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [NBANK-1:0]             bank_ce;
    logic [NBANK-1:0]             bank_we;
    logic [NBANK-1:0]             bank_oe_n;
    logic [BA_W-1:0]              bank_addr;
    logic [NBANK-1:0][DATA_W-1:0] bank_rdata;

    bank_decoder #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .bank_ce   (bank_ce),
        .bank_we   (bank_we),
        .bank_addr (bank_addr)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_array #(.BA_W(BA_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (bank_ce[b]),
            .we    (bank_we[b]),
            .oe_n  (bank_oe_n[b]),
            .addr  (bank_addr),
            .wdata (wdata),
            .rdata (bank_rdata[b])
        );
    end

    read_select #(.DATA_W(DATA_W), .NBANK(NBANK)) u_rsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_ce    (bank_ce),
        .bank_rdata (bank_rdata),
        .bank_oe_n  (bank_oe_n),
        .rdata      (rdata)
    );

    // Exactly one bank is enabled on each cycle out of reset.
    assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_ce) == 1);

    // No bank sees a write strobe without its chip enable.
    assert_we_needs_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we & ~bank_ce) == '0);

    // The active output enable belongs to the bank enabled one edge earlier.
    assert_oe_follows_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (~bank_oe_n == $past(bank_ce)));

    // A write is visible on the read data in the following cycle.
    assert_write_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata == $past(wdata)));

endmodule

// File: tb/split_bank_mem_tb.sv
`timescale 1ns/1ps
// Bench for the two-bank split memory: a vector table walked by one loop,
// then directed reset and latency tests.
module split_bank_mem_tb;

    localparam int AW = 11;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;

    int checks = 0;
    int errors = 0;

    split_bank_mem #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .wdata (wdata),
        .rdata (rdata)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [DW-1:0] exp;
        int            req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 11'd0,    32'hA000_0000, 32'hA000_0000, 5},  // R5 write even
        '{1'b1, 11'd1,    32'hB000_0001, 32'hB000_0001, 5},  // R5 write odd
        '{1'b1, 11'd2,    32'hC000_0002, 32'hC000_0002, 5},
        '{1'b1, 11'd3,    32'hD000_0003, 32'hD000_0003, 5},
        '{1'b0, 11'd0,    32'h0,         32'hA000_0000, 7},  // R7 alternating reads
        '{1'b0, 11'd1,    32'h0,         32'hB000_0001, 7},
        '{1'b0, 11'd2,    32'h0,         32'hC000_0002, 7},
        '{1'b0, 11'd3,    32'h0,         32'hD000_0003, 7},
        '{1'b0, 11'd0,    32'h0,         32'hA000_0000, 7},
        '{1'b0, 11'd3,    32'h0,         32'hD000_0003, 7},
        '{1'b1, 11'd1,    32'hE000_0001, 32'hE000_0001, 5},  // overwrite odd word
        '{1'b0, 11'd0,    32'h0,         32'hA000_0000, 6},  // R6 even bank untouched
        '{1'b0, 11'd2,    32'h0,         32'hC000_0002, 6},
        '{1'b0, 11'd1,    32'h0,         32'hE000_0001, 5},
        '{1'b1, 11'd4,    32'h1111_0004, 32'h1111_0004, 2},  // R2 neighbours
        '{1'b1, 11'd5,    32'h2222_0005, 32'h2222_0005, 2},
        '{1'b0, 11'd4,    32'h0,         32'h1111_0004, 2},
        '{1'b0, 11'd5,    32'h0,         32'h2222_0005, 2},
        '{1'b1, 11'd2046, 32'h3333_07FE, 32'h3333_07FE, 3},  // R3 top of range
        '{1'b1, 11'd2047, 32'h4444_07FF, 32'h4444_07FF, 3},
        '{1'b0, 11'd2046, 32'h0,         32'h3333_07FE, 3},
        '{1'b0, 11'd2,    32'h0,         32'hC000_0002, 3}   // low word kept
    };

    task automatic check(input int req, input logic [DW-1:0] exp, input string what);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL R%0d %s: rdata=%h expected=%h", req, what, rdata, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog expired: rdata=%h expected=finished run", rdata);
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, '0, "rdata after reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i].we;
            addr  = VEC[i].a;
            wdata = VEC[i].d;
            @(posedge clk);
            @(negedge clk);
            check(VEC[i].req, VEC[i].exp, $sformatf("vector %0d", i));
        end

        // R4: read data does not change before the edge that takes the address
        wr_en = 1'b0;
        addr  = 11'd5;
        #2;
        check(4, 32'hC000_0002, "old word before edge");
        @(posedge clk);
        @(negedge clk);
        check(4, 32'h2222_0005, "new word after edge");

        // R1: a write held during reset must not take effect
        rst_n = 1'b0;
        wr_en = 1'b1;
        addr  = 11'd0;
        wdata = 32'hDEAD_BEEF;
        @(posedge clk);
        @(negedge clk);
        check(1, '0, "rdata during reset");
        rst_n = 1'b1;
        wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(1, 32'hA000_0000, "word kept through reset write");

        // R7: alternate odd/even reads after reset
        addr = 11'd2047;
        @(posedge clk);
        @(negedge clk);
        check(7, 32'h4444_07FF, "odd top word");
        addr = 11'd4;
        @(posedge clk);
        @(negedge clk);
        check(7, 32'h1111_0004, "even word");

        summary();
        $finish;
    end

endmodule